// File: doc/BRIEF.md
# CMI Line Encoder with Violation Injection

This block turns a serial NRZ bit stream into Coded Mark Inversion (CMI) line symbols. It runs on a clock at twice the bit rate. A one-cycle `bit_en` pulse, given once every two cycles, marks the start of each bit. The block then drives two half-bit symbols onto `line_out`. A zero becomes a low half followed by a high half. A one becomes a flat level for the whole bit, and that level alternates from one mark to the next. When `cmi_mode` is low the encoder is bypassed: the line carries the registered NRZ data, held for the whole bit.

For diagnostics, a request sampled with each bit forces a code violation. On a zero the block sends the inverted symbol pair. On a one it sends the level the alternation did not call for, and later marks alternate from the level actually sent. As a result, one injected error gives exactly one violation on the line.

An independent monitor watches the line itself and reports a 3-bit status: disabled, healthy, stuck high, stuck low or non-CMI. The reset input is active low and acts on the clock edge.

Top module: `cmi_tx_encoder`

## Requirements
- R1: While `rst_n` is sampled low, `line_out` is 0 after the edge, the status is DISABLED (code 0), and the ones level returns to low.
- R2: In CMI mode, a zero bit with no violation request is shown as 0 after the `bit_en` edge and as 1 after the following edge.
- R3: In CMI mode, a one bit is shown at the same level in both halves. Successive ones alternate, and the first one after reset is low.
- R4: A violation request on a zero bit sends 1 in the first half and 0 in the second half, and leaves the ones level unchanged.
- R5: A violation request on a one bit sends the level opposite to the expected one. The next ones alternate from the level actually sent.
- R6: The violation request is sampled on every `bit_en` edge, so consecutive bits can each carry a violation.
- R7: In NRZ mode (`cmi_mode`=0), `line_out` equals the `data_in` sampled on the `bit_en` edge for both halves of the bit, and `viol_req` has no effect.
- R8: While `cmi_mode` is low, the status reads DISABLED (code 0) after each edge.
- R9: The monitor checks each completed CMI bit on the line. Valid pairs are 01 and a flat pair that alternates with the previous flat pair. After the edge that begins the following bit, the status is HEALTHY (code 1) for a valid bit and NON_CMI (code 4) for an invalid one.
- R10: When the line stays low for `STUCK_LIMIT` consecutive edges (default 256), the status reads STUCK_LOW (code 3).
- R11: When the line stays high for `STUCK_LIMIT` consecutive edges, the status reads STUCK_HIGH (code 2). A stuck state takes priority over NON_CMI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit-rate clock (twice the bit rate) |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | One-cycle pulse marking the start of each bit, one cycle in two |
| data_in | input | 1 | NRZ data bit, sampled with `bit_en` |
| cmi_mode | input | 1 | 1 selects CMI encoding, 0 selects NRZ bypass |
| viol_req | input | 1 | Diagnostic code violation request, sampled with `bit_en` |
| line_out | output | 1 | Serial line output |
| status | output | 3 | 0 disabled, 1 healthy, 2 stuck high, 3 stuck low, 4 non-CMI |

## Verification
The hardest states to reach from the ports are the stuck conditions during live traffic. A correct CMI stream changes level at least once every three half-bits, so under normal traffic the run counter never saturates. The bench reaches a stuck-high line by requesting a violation on every one bit of an all-ones stream: each violated mark repeats the level of the mark before it, so the line sits high. Along the way it confirms that NON_CMI is shown first and then yields to STUCK_HIGH. Stuck-low is reached by stopping `bit_en` after reset.

// File: rtl/cmi_tx_pkg.sv
package cmi_tx_pkg;

    localparam int STAT_W = 3;

    typedef enum logic [STAT_W-1:0] {
        ST_DISABLED = 3'd0,
        ST_HEALTHY  = 3'd1,
        ST_STUCK_HI = 3'd2,
        ST_STUCK_LO = 3'd3,
        ST_NON_CMI  = 3'd4
    } cmi_stat_e;

    typedef struct packed {
        logic first_half;
        logic second_half;
        logic next_level;
    } cmi_sym_t;

    // Build the half-bit symbol pair for one data bit.
    function automatic cmi_sym_t cmi_encode(input logic bit_val,
                                            input logic force_bad,
                                            input logic mark_level);
        cmi_sym_t s;
        if (bit_val) begin
            s.first_half  = mark_level ^ force_bad;
            s.second_half = mark_level ^ force_bad;
            s.next_level  = ~(mark_level ^ force_bad);
        end else begin
            s.first_half  = force_bad;
            s.second_half = ~force_bad;
            s.next_level  = mark_level;
        end
        return s;
    endfunction

    // Judge a completed flat or split symbol pair.
    function automatic logic cmi_pair_bad(input logic h0,
                                          input logic h1,
                                          input logic prev_mark);
        logic bad;
        if (h0 == h1) bad = (h0 == prev_mark);
        else          bad = h0;
        return bad;
    endfunction

endpackage

// File: rtl/cmi_sym_gen.sv
module cmi_sym_gen
    import cmi_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic data_in,
    input  logic cmi_mode,
    input  logic viol_req,
    output logic line_q,
    output logic show_first,
    output logic show_second,
    output logic bit_was_cmi
);

    logic     mark_level_q;
    logic     pend_half_q;
    cmi_sym_t sym;

    always_comb begin
        sym = cmi_encode(data_in, viol_req, mark_level_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q       <= 1'b0;
            mark_level_q <= 1'b0;
            pend_half_q  <= 1'b0;
            show_first   <= 1'b0;
            show_second  <= 1'b0;
            bit_was_cmi  <= 1'b0;
        end else if (bit_en) begin
            show_first  <= 1'b1;
            show_second <= 1'b0;
            if (cmi_mode) begin
                line_q       <= sym.first_half;
                pend_half_q  <= sym.second_half;
                mark_level_q <= sym.next_level;
                bit_was_cmi  <= 1'b1;
            end else begin
                line_q      <= data_in;
                pend_half_q <= data_in;
                bit_was_cmi <= 1'b0;
            end
        end else if (show_first) begin
            line_q      <= pend_half_q;
            show_first  <= 1'b0;
            show_second <= 1'b1;
        end else begin
            show_second <= 1'b0;
        end
    end

endmodule

// File: rtl/cmi_run_cnt.sv
module cmi_run_cnt #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    output logic stuck,
    output logic level
);

    localparam int RUN_W = $clog2(LIMIT + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(LIMIT);

    logic [RUN_W-1:0] run_q;
    logic             prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            prev_q <= line;
            if (line != prev_q)      run_q <= '0;
            else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
        end
    end

    assign stuck = (run_q == RUN_MAX);
    assign level = prev_q;

endmodule

// File: rtl/cmi_line_mon.sv
module cmi_line_mon
    import cmi_tx_pkg::*;
#(
    parameter int STUCK_LIMIT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmi_mode,
    input  logic              line,
    input  logic              show_first,
    input  logic              show_second,
    input  logic              bit_was_cmi,
    output logic [STAT_W-1:0] status
);

    logic      first_q;
    logic      last_mark_q;
    logic      nc_q;
    logic      stuck;
    logic      stuck_lvl;
    logic      pair_done;
    logic      pair_bad;
    logic      nc_cur;
    cmi_stat_e stat_q;

    cmi_run_cnt #(.LIMIT(STUCK_LIMIT)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .line  (line),
        .stuck (stuck),
        .level (stuck_lvl)
    );

    always_comb begin
        pair_done = show_second && bit_was_cmi;
        pair_bad  = cmi_pair_bad(first_q, line, last_mark_q);
        nc_cur    = pair_done ? pair_bad : nc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q     <= 1'b0;
            last_mark_q <= 1'b1;
            nc_q        <= 1'b0;
            stat_q      <= ST_DISABLED;
        end else begin
            if (show_first) first_q <= line;
            if (pair_done) begin
                nc_q <= pair_bad;
                if (first_q == line) last_mark_q <= line;
            end
            if (!cmi_mode)   stat_q <= ST_DISABLED;
            else if (stuck)  stat_q <= stuck_lvl ? ST_STUCK_HI : ST_STUCK_LO;
            else if (nc_cur) stat_q <= ST_NON_CMI;
            else             stat_q <= ST_HEALTHY;
        end
    end

    assign status = stat_q;

endmodule

// File: rtl/cmi_tx_encoder.sv
module cmi_tx_encoder
    import cmi_tx_pkg::*;
#(
    parameter int STUCK_LIMIT = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       data_in,
    input  logic       cmi_mode,
    input  logic       viol_req,
    output logic       line_out,
    output logic [2:0] status
);

    logic line_q;
    logic show_first;
    logic show_second;
    logic bit_was_cmi;

    cmi_sym_gen u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .data_in     (data_in),
        .cmi_mode    (cmi_mode),
        .viol_req    (viol_req),
        .line_q      (line_q),
        .show_first  (show_first),
        .show_second (show_second),
        .bit_was_cmi (bit_was_cmi)
    );

    cmi_line_mon #(.STUCK_LIMIT(STUCK_LIMIT)) u_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmi_mode    (cmi_mode),
        .line        (line_q),
        .show_first  (show_first),
        .show_second (show_second),
        .bit_was_cmi (bit_was_cmi),
        .status      (status)
    );

    assign line_out = line_q;

endmodule

// File: rtl/cmi_tx_encoder_chk.sv
module cmi_tx_encoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       data_in,
    input logic       cmi_mode,
    input logic       viol_req,
    input logic       line_out,
    input logic [2:0] status
);

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (line_out == 1'b0 && status == 3'd0));

    // R2
    a_r2_zero_split: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cmi_mode && !data_in && !viol_req) |=> (!line_out ##1 line_out));

    // R4
    a_r4_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cmi_mode && !data_in && viol_req) |=> (line_out ##1 !line_out));

    // R3
    a_r3_mark_flat: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && cmi_mode && data_in) |=> ##1 $stable(line_out));

    // R7
    a_r7_nrz_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !cmi_mode) |=> (line_out == $past(data_in)));

    // R8
    a_r8_nrz_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !cmi_mode |=> (status == 3'd0));

    // R9
    a_r9_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status <= 3'd4));

endmodule

bind cmi_tx_encoder cmi_tx_encoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .data_in  (data_in),
    .cmi_mode (cmi_mode),
    .viol_req (viol_req),
    .line_out (line_out),
    .status   (status)
);

// File: tb/cmi_tx_encoder_tb.sv
`timescale 1ns/1ps
module cmi_tx_encoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       data_in = 1'b0;
    logic       cmi_mode = 1'b1;
    logic       viol_req = 1'b0;
    logic       line_out;
    logic [2:0] status;

    int n_run = 0;
    int n_fail = 0;
    logic exp_lvl = 1'b0;
    logic f_s, s_s;
    logic [2:0] st_s;

    always #2.5 clk = ~clk;

    cmi_tx_encoder u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .data_in  (data_in),
        .cmi_mode (cmi_mode),
        .viol_req (viol_req),
        .line_out (line_out),
        .status   (status)
    );

    task automatic check(input int act, input int exp, input string req);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; viol_req = 1'b0;
        repeat (3) @(negedge clk);
        check(line_out, 0, "R1 line in reset");
        check(status, 0, "R1 status in reset");
        rst_n = 1'b1;
        exp_lvl = 1'b0;
        @(negedge clk);
    endtask

    // Sends one bit; st_s is the status after its start edge (previous bit's verdict).
    task automatic send_bit(input logic d, input logic v);
        data_in = d; viol_req = v; bit_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        f_s = line_out; st_s = status;
        bit_en = 1'b0; viol_req = 1'b0;
        @(posedge clk);
        @(negedge clk);
        s_s = line_out;
    endtask

    // Sends a CMI bit and checks both halves against the model.
    task automatic cmi_bit(input logic d, input logic v, input string req);
        logic ef, es;
        if (d) begin
            ef = exp_lvl ^ v; es = ef; exp_lvl = ~ef;
        end else begin
            ef = v; es = ~v;
        end
        send_bit(d, v);
        check(f_s, ef, req);
        check(s_s, es, req);
    endtask

    task automatic t_reset_state();
        do_reset();
        check(status, 1, "R9 healthy after reset");
    endtask

    task automatic t_zeros();
        do_reset();
        for (int i = 0; i < 3; i++) cmi_bit(1'b0, 1'b0, "R2 zero split");
    endtask

    task automatic t_ones();
        do_reset();
        cmi_bit(1'b1, 1'b0, "R3 first one low");
        cmi_bit(1'b1, 1'b0, "R3 alternate");
        cmi_bit(1'b0, 1'b0, "R2 zero between");
        cmi_bit(1'b1, 1'b0, "R3 alternate across zero");
        cmi_bit(1'b1, 1'b0, "R3 alternate");
        check(st_s, 1, "R9 healthy stream");
    endtask

    task automatic t_viol_zero();
        do_reset();
        cmi_bit(1'b0, 1'b1, "R4 inverted zero");
        cmi_bit(1'b1, 1'b0, "R4 ones level kept");
        check(st_s, 4, "R9 non-CMI after bad zero");
        cmi_bit(1'b0, 1'b0, "R2 zero");
        check(st_s, 1, "R9 healthy again");
    endtask

    task automatic t_viol_one();
        do_reset();
        cmi_bit(1'b1, 1'b0, "R3 low one");
        cmi_bit(1'b1, 1'b1, "R5 violated one");
        check(f_s, 0, "R5 repeated low");
        cmi_bit(1'b1, 1'b0, "R5 alternate from sent");
        check(f_s, 1, "R5 high after sent low");
        check(st_s, 4, "R9 non-CMI after bad one");
        cmi_bit(1'b1, 1'b0, "R5 alternate");
        check(st_s, 1, "R5 no error multiplication");
    endtask

    task automatic t_stuck_high();
        do_reset();
        cmi_bit(1'b1, 1'b1, "R6 first violation");
        cmi_bit(1'b1, 1'b1, "R6 second violation");
        check(st_s, 4, "R6 status non-CMI");
        for (int i = 0; i < 30; i++) cmi_bit(1'b1, 1'b1, "R6 repeated violation");
        check(st_s, 4, "R11 not yet stuck");
        for (int i = 0; i < 130; i++) cmi_bit(1'b1, 1'b1, "R6 repeated violation");
        check(line_out, 1, "R11 line high");
        check(status, 2, "R11 stuck high over non-CMI");
    endtask

    task automatic t_stuck_low();
        do_reset();
        repeat (100) @(negedge clk);
        check(status, 1, "R10 not yet stuck");
        repeat (200) @(negedge clk);
        check(status, 3, "R10 stuck low");
        cmi_bit(1'b0, 1'b0, "R2 zero after idle");
        cmi_bit(1'b0, 1'b0, "R2 zero after idle");
        check(status, 1, "R10 recovers");
    endtask

    task automatic t_nrz();
        do_reset();
        cmi_mode = 1'b0;
        send_bit(1'b1, 1'b1);
        check(f_s, 1, "R7 nrz one first half");
        check(s_s, 1, "R7 nrz one second half");
        send_bit(1'b0, 1'b1);
        check(f_s, 0, "R7 nrz zero ignores viol");
        check(s_s, 0, "R7 nrz zero second half");
        check(status, 0, "R8 disabled in nrz");
        send_bit(1'b1, 1'b0);
        check(s_s, 1, "R7 nrz one");
        cmi_mode = 1'b1;
    endtask

    task automatic t_reset_mid();
        do_reset();
        cmi_bit(1'b1, 1'b1, "R5 high one");
        data_in = 1'b1; bit_en = 1'b1; rst_n = 1'b0;
        @(negedge clk);
        bit_en = 1'b0;
        check(line_out, 0, "R1 reset overrides");
        check(status, 0, "R1 status cleared");
        rst_n = 1'b1; exp_lvl = 1'b0;
        @(negedge clk);
        cmi_bit(1'b1, 1'b0, "R1 ones level reset to low");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_zeros();
        t_ones();
        t_viol_zero();
        t_viol_one();
        t_stuck_high();
        t_stuck_low();
        t_nrz();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule